// File: doc/BRIEF.md
# Instruction Fetch Unit with Branch and Jump

This block owns the program counter of a single-cycle processor. Each cycle it presents the current fetch address and the instruction word read from a small internal read-only instruction store. It also works out the address for the next cycle. That address is one of three things:

- the sequential successor, four bytes on;
- a PC-relative branch target;
- a region-relative jump target.

The surrounding control supplies a single "this is a branch" bit. The block gates that bit with the datapath's equality flag, so the control logic never drives the next-address multiplexer directly.

The branch offset is the low immediate field of the word being fetched. A sign extender and a two-bit shift inside the block widen it; this extender is separate from the one in the datapath. The jump target field arrives as an input. It is spliced below the top bits of the incremented address. The store is indexed by the word address, and addresses past its depth alias back into it. Its contents come from a closed-form rule, so every word is known without a loaded image.

Top module: `ifetch_unit`

## Requirements
- R1: When `rst` is 1 at a rising clock edge, `pc_o` becomes 0 after that edge, whatever the other inputs are.
- R2: `instr_o` follows `pc_o` combinationally and is the store word at index `pc_o[IDX_W+1:2]`, where IDX_W = log2(IMEM_DEPTH). Addresses beyond the store alias modulo its depth.
- R3: Store word i is built from two parts. The bits above the low IMM_W bits hold (ROM_TAG + i) truncated to INSTR_W-IMM_W bits. The low IMM_W bits hold (i mod 8) - 4 in two's complement.
- R4: With `br_sel_i` = 0 and `jump_i` = 0, the next `pc_o` is `pc_o` + 4, whether `equal_i` is 0 or 1.
- R5: With `br_sel_i` = 1, `equal_i` = 1 and `jump_i` = 0, the next `pc_o` is `pc_o` + 4 + (sign-extended `instr_o[IMM_W-1:0]` shifted left by 2).
- R6: With `br_sel_i` = 1, `equal_i` = 0 and `jump_i` = 0, the next `pc_o` is `pc_o` + 4.
- R7: With `jump_i` = 1, the next `pc_o` is built from three fields, high to low: the top ADDR_W-JUMP_W-2 bits of (`pc_o` + 4), then `jump_target_i`, then 2'b00. This holds even when the branch condition is also true.
- R8: `pc_o[1:0]` is always 2'b00 outside reset.
- R9: All address arithmetic wraps modulo 2^ADDR_W. A backward branch from address 0 lands near the top of the address space, and stepping past the top returns to 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; the PC updates on the rising edge |
| rst | input | 1 | Synchronous reset, active high |
| br_sel_i | input | 1 | Control bit marking the current instruction as a conditional branch |
| equal_i | input | 1 | Operand equality flag from the datapath |
| jump_i | input | 1 | Control bit selecting the jump target; overrides the branch |
| jump_target_i | input | JUMP_W | Word-address field of the jump target |
| pc_o | output | ADDR_W | Current fetch address |
| instr_o | output | INSTR_W | Instruction word at the current fetch address |

## Verification
The bench keeps the 32-bit address, 32-bit word, 16-bit immediate and 26-bit jump field. It shrinks the store to 16 words. With the smaller store, a few sequential steps and jumps carry the PC past the end of the store, which exercises the aliasing of R2. Under this build, a taken branch straight after reset uses the offset -4 stored at word 0. That drives the PC below zero into the top of the address space, and a few increments then wrap it back to 0. This covers R9 without a long run.

// File: rtl/ifu_pkg.sv
package ifu_pkg;
   typedef enum logic [1:0] {
      NPC_SEQ    = 2'd0,
      NPC_BRANCH = 2'd1,
      NPC_JUMP   = 2'd2
   } npc_src_e;
endpackage

// File: rtl/ifu_pc_reg.sv
module ifu_pc_reg #(
   parameter int ADDR_W = 32
) (
   input  logic              clk,
   input  logic              rst,
   input  logic [ADDR_W-1:0] pc_d,
   output logic [ADDR_W-1:0] pc_q
);
   always_ff @(posedge clk) begin
      if (rst) pc_q <= '0;
      else     pc_q <= pc_d;
   end

   // R1
   pc_reset_chk: assert property (@(posedge clk) rst |=> pc_q == '0);
endmodule

// File: rtl/ifu_next_pc.sv
module ifu_next_pc
   import ifu_pkg::*;
#(
   parameter int ADDR_W = 32,
   parameter int IMM_W  = 16,
   parameter int JUMP_W = 26
) (
   input  logic [ADDR_W-1:0] pc_i,
   input  logic [IMM_W-1:0]  imm_i,
   input  logic              br_sel_i,
   input  logic              equal_i,
   input  logic              jump_i,
   input  logic [JUMP_W-1:0] target_i,
   output logic [ADDR_W-1:0] pc_next_o,
   output npc_src_e          src_o
);
   localparam int EXT_W = ADDR_W - IMM_W - 2;
   localparam int HI_W  = ADDR_W - JUMP_W - 2;

   if (EXT_W < 1) begin : g_bad_imm
      $error("ifu_next_pc: ADDR_W must exceed IMM_W + 2");
   end
   if (HI_W < 1) begin : g_bad_jump
      $error("ifu_next_pc: ADDR_W must exceed JUMP_W + 2");
   end

   logic [ADDR_W-1:0] pc_inc;
   logic [ADDR_W-1:0] br_off;
   logic [ADDR_W-1:0] br_tgt;
   logic [ADDR_W-1:0] jmp_tgt;
   logic              take_br;

   // sequential adder
   assign pc_inc  = pc_i + ADDR_W'(4);
   // dedicated extender and shift for the branch offset
   assign br_off  = {{EXT_W{imm_i[IMM_W-1]}}, imm_i, 2'b00};
   // branch-target adder
   assign br_tgt  = pc_inc + br_off;
   assign jmp_tgt = {pc_inc[ADDR_W-1 -: HI_W], target_i, 2'b00};
   // the mux select is qualified by the datapath flag
   assign take_br = br_sel_i & equal_i;

   always_comb begin
      if (jump_i)       src_o = NPC_JUMP;
      else if (take_br) src_o = NPC_BRANCH;
      else              src_o = NPC_SEQ;
   end

   always_comb begin
      unique case (src_o)
         NPC_JUMP:   pc_next_o = jmp_tgt;
         NPC_BRANCH: pc_next_o = br_tgt;
         default:    pc_next_o = pc_inc;
      endcase
   end
endmodule

// File: rtl/ifu_imem.sv
module ifu_imem #(
   parameter int          ADDR_W     = 32,
   parameter int          INSTR_W    = 32,
   parameter int          IMM_W      = 16,
   parameter int          IMEM_DEPTH = 256,
   parameter int unsigned ROM_TAG    = 32'h8C00
) (
   input  logic [ADDR_W-1:0]  pc_i,
   output logic [INSTR_W-1:0] instr_o
);
   localparam int IDX_W = $clog2(IMEM_DEPTH);
   localparam int UP_W  = INSTR_W - IMM_W;

   if (IMEM_DEPTH < 2 || (1 << IDX_W) != IMEM_DEPTH) begin : g_bad_depth
      $error("ifu_imem: IMEM_DEPTH must be a power of two, at least 2");
   end
   if (UP_W < 1) begin : g_bad_width
      $error("ifu_imem: INSTR_W must exceed IMM_W");
   end
   if (IDX_W + 2 > ADDR_W) begin : g_bad_addr
      $error("ifu_imem: store index does not fit in the address");
   end

   logic [INSTR_W-1:0] rom [IMEM_DEPTH];

   for (genvar i = 0; i < IMEM_DEPTH; i++) begin : g_word
      assign rom[i] = {UP_W'(ROM_TAG + i), IMM_W'((i % 8) - 4)};
   end

   assign instr_o = rom[pc_i[IDX_W+1:2]];
endmodule

// File: rtl/ifetch_unit.sv
module ifetch_unit
   import ifu_pkg::*;
#(
   parameter int          ADDR_W     = 32,
   parameter int          INSTR_W    = 32,
   parameter int          IMM_W      = 16,
   parameter int          JUMP_W     = 26,
   parameter int          IMEM_DEPTH = 256,
   parameter int unsigned ROM_TAG    = 32'h8C00
) (
   input  logic               clk,
   input  logic               rst,
   input  logic               br_sel_i,
   input  logic               equal_i,
   input  logic               jump_i,
   input  logic [JUMP_W-1:0]  jump_target_i,
   output logic [ADDR_W-1:0]  pc_o,
   output logic [INSTR_W-1:0] instr_o
);
   localparam int EXT_W = ADDR_W - IMM_W - 2;

   logic [ADDR_W-1:0] pc_next;
   npc_src_e          npc_src;

   ifu_pc_reg #(.ADDR_W(ADDR_W)) u_pc (
      .clk  (clk),
      .rst  (rst),
      .pc_d (pc_next),
      .pc_q (pc_o)
   );

   ifu_imem #(
      .ADDR_W(ADDR_W), .INSTR_W(INSTR_W), .IMM_W(IMM_W),
      .IMEM_DEPTH(IMEM_DEPTH), .ROM_TAG(ROM_TAG)
   ) u_imem (
      .pc_i    (pc_o),
      .instr_o (instr_o)
   );

   ifu_next_pc #(.ADDR_W(ADDR_W), .IMM_W(IMM_W), .JUMP_W(JUMP_W)) u_npc (
      .pc_i      (pc_o),
      .imm_i     (instr_o[IMM_W-1:0]),
      .br_sel_i  (br_sel_i),
      .equal_i   (equal_i),
      .jump_i    (jump_i),
      .target_i  (jump_target_i),
      .pc_next_o (pc_next),
      .src_o     (npc_src)
   );

   // R8
   pc_align_chk: assert property (@(posedge clk) disable iff (rst)
      pc_o[1:0] == 2'b00);

   // R4
   seq_step_chk: assert property (@(posedge clk) disable iff (rst)
      (!br_sel_i && !jump_i) |=> pc_o == $past(pc_o) + ADDR_W'(4));

   // R6
   br_not_taken_chk: assert property (@(posedge clk) disable iff (rst)
      (br_sel_i && !equal_i && !jump_i) |=> pc_o == $past(pc_o) + ADDR_W'(4));

   // R5
   br_taken_chk: assert property (@(posedge clk) disable iff (rst)
      (br_sel_i && equal_i && !jump_i) |=>
      pc_o - $past(pc_o) - ADDR_W'(4) ==
      {{EXT_W{$past(instr_o[IMM_W-1])}}, $past(instr_o[IMM_W-1:0]), 2'b00});

   // R7
   jump_field_chk: assert property (@(posedge clk) disable iff (rst)
      jump_i |=> pc_o[JUMP_W+1:2] == $past(jump_target_i));
endmodule

// File: tb/ifetch_unit_tb.sv
module ifetch_unit_tb;
   localparam int          ADDR_W     = 32;
   localparam int          INSTR_W    = 32;
   localparam int          IMM_W      = 16;
   localparam int          JUMP_W     = 26;
   localparam int          IMEM_DEPTH = 16;
   localparam int unsigned ROM_TAG    = 32'h8C00;

   logic               clk = 1'b0;
   logic               rst = 1'b1;
   logic               br_sel = 1'b0;
   logic               eq = 1'b0;
   logic               jmp = 1'b0;
   logic [JUMP_W-1:0]  tgt = '0;
   logic [ADDR_W-1:0]  pc_o;
   logic [INSTR_W-1:0] instr_o;

   always #4 clk = ~clk;

   ifetch_unit #(
      .ADDR_W(ADDR_W), .INSTR_W(INSTR_W), .IMM_W(IMM_W), .JUMP_W(JUMP_W),
      .IMEM_DEPTH(IMEM_DEPTH), .ROM_TAG(ROM_TAG)
   ) u_dut (
      .clk(clk), .rst(rst), .br_sel_i(br_sel), .equal_i(eq), .jump_i(jmp),
      .jump_target_i(tgt), .pc_o(pc_o), .instr_o(instr_o)
   );

   typedef struct {
      logic [ADDR_W-1:0] pc;
      string             req;
   } exp_t;

   exp_t              sb_q[$];
   int                checks = 0;
   int                errors = 0;
   bit                done = 0;
   logic [ADDR_W-1:0] model_pc = '0;

   // R3: word i = {(ROM_TAG + i), (i mod 8) - 4}; R2: index aliases modulo depth
   function automatic logic [INSTR_W-1:0] rom_model(logic [ADDR_W-1:0] a);
      int unsigned idx;
      idx = (a >> 2) % IMEM_DEPTH;
      return {16'(ROM_TAG + idx), 16'(int'(idx % 8) - 4)};
   endfunction

   task automatic check(logic [63:0] act, logic [63:0] exp, string req);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic drive(logic r, logic s, logic e, logic j,
                        logic [JUMP_W-1:0] t, string req);
      logic [ADDR_W-1:0] inc, nxt;
      logic [IMM_W-1:0]  imm;
      exp_t              it;
      @(negedge clk);
      rst = r; br_sel = s; eq = e; jmp = j; tgt = t;
      inc = model_pc + 32'd4;
      imm = rom_model(model_pc)[IMM_W-1:0];
      if (r)           nxt = '0;
      else if (j)      nxt = {inc[31:28], t, 2'b00};
      else if (s && e) nxt = inc + {{14{imm[15]}}, imm, 2'b00};
      else             nxt = inc;
      it.pc = nxt; it.req = req;
      sb_q.push_back(it);
      model_pc = nxt;
   endtask

   // monitor: one item per rising edge, sampled 1 ns after it
   initial begin
      exp_t it;
      forever begin
         @(posedge clk);
         #1;
         if (sb_q.size() > 0) begin
            it = sb_q.pop_front();
            check(64'(pc_o), 64'(it.pc), it.req);
            check(64'(instr_o), 64'(rom_model(it.pc)), "R2 R3 word");
            check(64'(pc_o[1:0]), 64'd0, "R8 alignment");
         end
      end
   end

   task automatic finish_run();
      if (!done) begin
         done = 1;
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   endtask

   initial begin
      #(8 * 20000);
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
   end

   initial begin
      // R1 reset holds PC at 0
      drive(1, 0, 0, 0, '0, "R1 reset");
      drive(1, 1, 1, 1, 26'h3FFFFFF, "R1 reset with busy inputs");
      // R5 + R9: taken branch at word 0 (offset -4) wraps below zero
      drive(0, 1, 1, 0, '0, "R5 R9 backward branch from 0");
      drive(0, 0, 1, 0, '0, "R4 step, equal ignored");
      drive(0, 0, 0, 0, '0, "R4 step");
      drive(0, 0, 1, 0, '0, "R9 wrap to 0");
      // R4 steps with Equal toggling, passing the store end (R2 aliasing)
      for (int k = 0; k < 18; k++)
         drive(0, 0, k[0], 0, '0, "R4 sequential");
      // R6 branch not taken
      drive(0, 1, 0, 0, '0, "R6 not taken");
      drive(0, 1, 0, 0, '0, "R6 not taken");
      // R5 taken branches with differing offsets
      for (int k = 0; k < 6; k++)
         drive(0, 1, 1, 0, '0, "R5 taken");
      // R7 jump overrides a true branch condition
      drive(0, 1, 1, 1, 26'h2ABCDE5, "R7 jump over branch");
      drive(0, 0, 0, 1, 26'h0000123, "R7 jump");
      drive(0, 0, 1, 1, 26'h3FFFFFF, "R7 jump to region top");
      drive(0, 0, 0, 0, '0, "R4 step after jump");
      // R1 mid-run reset
      drive(1, 1, 1, 1, 26'h1555555, "R1 mid-run reset");
      drive(0, 0, 0, 0, '0, "R4 step after reset");
      drive(0, 1, 1, 0, '0, "R5 taken after reset");
      @(negedge clk);
      br_sel = 0; eq = 0; jmp = 0;
      wait (sb_q.size() == 0);
      @(posedge clk);
      #2;
      finish_run();
   end
endmodule